// File: doc/BRIEF.md
# Serial Peripheral Select and Backlight Decoder

This block sits on the slave side of a shared serial port that carries words to and from three peripherals: a display timing controller, a touch controller and an ADC. Three active-low select inputs decide where each transferred word goes. A written word is copied to every peripheral whose select is low. A read returns the data of one selected peripheral, chosen by a fixed priority.

The display timing controller is built into the block. Its command byte carries a register address and a small value. Two addresses have an effect: one sets the panel resolution mode and one sets the low five bits of a six-bit backlight intensity. The top intensity bit follows a separate discrete input through an inversion. A backlight power input gates the effective output and also gates the change notification. The touch controller and the ADC appear only as generic write strobes and read-data ports.

Top module: `sbl_top`

## Requirements
- R1: After reset the intensity is 0x20, the resolution mode is full (qres_o = 0), the power state is off, bl_on_o = 0 and bl_change_o = 0.
- R2: Select bit order is cs_n_i[0] display, cs_n_i[1] touch, cs_n_i[2] ADC. While wr_valid_i is high, touch_wr_o and adc_wr_o are high combinationally whenever their own select is low, including both at once. periph_wr_data_o equals wr_data_i.
- R3: rd_data_o is zero when the display select is low. Otherwise it is touch_rd_data_i if the touch select is low, else adc_rd_data_i if the ADC select is low, else zero.
- R4: A display command is wr_data_i[7:0]. Bits 7..5 hold the address and bits 4..0 hold the value. For address 0, a nonzero value sets qres_o to 1 and a zero value sets it to 0, one clock after the write.
- R5: Address 2 replaces intensity bits 4..0 with the value, one clock after the write. Bit 5 is unchanged.
- R6: Intensity bit 5 is the registered inverse of bl_hi_n_i. A high level clears it and a low level sets it, one clock later.
- R7: Display commands with addresses other than 0 and 2 change neither the intensity nor qres_o, and produce no change pulse.
- R8: While the power state is on, a duty write (address 2, even with an unchanged value) or a change of bit 5 produces a one-cycle bl_change_o pulse in the cycle the new value appears. While power is off, neither produces a pulse.
- R9: Any change of bl_pwr_i, rising or falling, is registered into the power state one clock later and produces a one-cycle bl_change_o pulse in that same cycle.
- R10: bl_on_o is high only when the power state is on and the intensity is nonzero.
- R11: A write with the display select high is not decoded as a display command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 3 | Selects, active low: [0] display, [1] touch, [2] ADC |
| wr_valid_i | input | 1 | A write word is present this cycle |
| wr_data_i | input | DW | Written word |
| rd_data_o | output | DW | Read word returned to the port |
| touch_wr_o | output | 1 | Write strobe to the touch controller |
| adc_wr_o | output | 1 | Write strobe to the ADC |
| periph_wr_data_o | output | DW | Write data to the touch controller and the ADC |
| touch_rd_data_i | input | DW | Touch controller read data |
| adc_rd_data_i | input | DW | ADC read data |
| bl_hi_n_i | input | 1 | Discrete line, inverted into intensity bit 5 |
| bl_pwr_i | input | 1 | Backlight power enable |
| bl_level_o | output | 6 | Backlight intensity |
| bl_on_o | output | 1 | Effective backlight on |
| bl_change_o | output | 1 | One-cycle change notification |
| qres_o | output | 1 | 1 = quarter resolution, 0 = full resolution |

## Verification
The routing paths are combinational, so a wrong select priority or a missing strobe shows at rd_data_o or at the strobe outputs in the same cycle. A corrupted intensity, resolution or power register shows at bl_level_o, qres_o or bl_on_o one clock after the write or input change that should have set it. A wrong gating term shows as a missing or extra bl_change_o pulse in that same cycle. Reserved-address commands are followed by reads of the intensity and mode outputs to show that nothing moved.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  parameter int unsigned CMD_AW = 3;
  parameter int unsigned CMD_VW = 5;
  parameter int unsigned CMD_W  = CMD_AW + CMD_VW;

  typedef struct packed {
    logic [CMD_AW-1:0] adr;
    logic [CMD_VW-1:0] val;
  } cmd_t;

  localparam logic [CMD_AW-1:0] ADR_RES  = CMD_AW'(0);
  localparam logic [CMD_AW-1:0] ADR_DUTY = CMD_AW'(2);

  // select index by role
  localparam int unsigned SEL_DISP  = 0;
  localparam int unsigned SEL_TOUCH = 1;
  localparam int unsigned SEL_ADC   = 2;
  localparam int unsigned NSEL      = 3;
endpackage

// File: rtl/sbl_route.sv
module sbl_route #(
  parameter int unsigned DW = 16,
  parameter int unsigned NP = 3
) (
  input  logic [NP-1:0]         cs_n_i,
  input  logic                  wr_valid_i,
  input  logic [NP-1:0][DW-1:0] rd_src_i,
  output logic [NP-1:0]         wr_stb_o,
  output logic [DW-1:0]         rd_data_o
);
  logic [NP-1:0] sel;
  assign sel = ~cs_n_i;

  for (genvar k = 0; k < NP; k++) begin : g_stb
    assign wr_stb_o[k] = wr_valid_i & sel[k];
  end

  // lowest index wins
  always_comb begin
    rd_data_o = '0;
    for (int k = NP - 1; k >= 0; k--) begin
      if (sel[k]) rd_data_o = rd_src_i[k];
    end
  end
endmodule

// File: rtl/sbl_bl_ctl.sv
module sbl_bl_ctl
  import sbl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_wr_i,
  input  cmd_t            cmd_i,
  input  logic            hi_n_i,
  input  logic            pwr_i,
  output logic [CMD_VW:0] level_o,
  output logic            qres_o,
  output logic            pwr_o,
  output logic            change_o
);
  localparam logic [CMD_VW:0] LVL_RST = (CMD_VW+1)'(1) << CMD_VW;

  logic [CMD_VW:0] lvl_q;
  logic            qres_q, pwr_q, chg_q;
  logic            duty_wr, res_wr, hi_nx, pwr_edge, chg_d;

  assign duty_wr  = cmd_wr_i && (cmd_i.adr == ADR_DUTY);
  assign res_wr   = cmd_wr_i && (cmd_i.adr == ADR_RES);
  assign hi_nx    = ~hi_n_i;
  assign pwr_edge = pwr_i != pwr_q;
  assign chg_d    = pwr_edge || (pwr_q && (duty_wr || (hi_nx != lvl_q[CMD_VW])));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= LVL_RST;
      qres_q <= 1'b0;
      pwr_q  <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      lvl_q[CMD_VW] <= hi_nx;
      if (duty_wr) lvl_q[CMD_VW-1:0] <= cmd_i.val;
      if (res_wr)  qres_q <= |cmd_i.val;
      pwr_q <= pwr_i;
      chg_q <= chg_d;
    end
  end

  assign level_o  = lvl_q;
  assign qres_o   = qres_q;
  assign pwr_o    = pwr_q;
  assign change_o = chg_q;

  p_bit5_inv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> level_o[CMD_VW] == !$past(hi_n_i));

  p_rsvd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_i.adr != ADR_RES && cmd_i.adr != ADR_DUTY
    |=> $stable(level_o[CMD_VW-1:0]) && $stable(qres_o));

  p_chg_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |-> ($past(pwr_o) || pwr_o));

  p_pwr_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i != pwr_o) |=> change_o);
endmodule

// File: rtl/sbl_top.sv
module sbl_top
  import sbl_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSEL-1:0] cs_n_i,
  input  logic            wr_valid_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            touch_wr_o,
  output logic            adc_wr_o,
  output logic [DW-1:0]   periph_wr_data_o,
  input  logic [DW-1:0]   touch_rd_data_i,
  input  logic [DW-1:0]   adc_rd_data_i,
  input  logic            bl_hi_n_i,
  input  logic            bl_pwr_i,
  output logic [CMD_VW:0] bl_level_o,
  output logic            bl_on_o,
  output logic            bl_change_o,
  output logic            qres_o
);
  logic [NSEL-1:0]         stb;
  logic [NSEL-1:0][DW-1:0] rd_src;
  logic                    pwr_st;

  // display returns zero on reads
  assign rd_src[SEL_DISP]  = '0;
  assign rd_src[SEL_TOUCH] = touch_rd_data_i;
  assign rd_src[SEL_ADC]   = adc_rd_data_i;

  sbl_route #(.DW(DW), .NP(NSEL)) u_route (
    .cs_n_i    (cs_n_i),
    .wr_valid_i(wr_valid_i),
    .rd_src_i  (rd_src),
    .wr_stb_o  (stb),
    .rd_data_o (rd_data_o)
  );

  assign touch_wr_o       = stb[SEL_TOUCH];
  assign adc_wr_o         = stb[SEL_ADC];
  assign periph_wr_data_o = wr_data_i;

  sbl_bl_ctl u_bl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_wr_i(stb[SEL_DISP]),
    .cmd_i   (cmd_t'(wr_data_i[CMD_W-1:0])),
    .hi_n_i  (bl_hi_n_i),
    .pwr_i   (bl_pwr_i),
    .level_o (bl_level_o),
    .qres_o  (qres_o),
    .pwr_o   (pwr_st),
    .change_o(bl_change_o)
  );

  assign bl_on_o = pwr_st && (bl_level_o != '0);

  p_wr_fan_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && !cs_n_i[SEL_TOUCH] |-> touch_wr_o);

  p_rd_disp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_i[SEL_DISP] |-> rd_data_o == '0);

  p_on_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bl_level_o == '0 |-> !bl_on_o);
endmodule

// File: tb/sim_sbl_top.sv
module sim_sbl_top;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cs_n = 3'b111;
  logic wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0, rd_data, pwd, trd = 16'hA5A5, ard = 16'h5A5A;
  logic twr, awr, hi_n = 1'b0, pwr = 1'b0, on, chg, qres;
  logic [5:0] lvl;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  sbl_top #(.DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .touch_wr_o(twr), .adc_wr_o(awr),
    .periph_wr_data_o(pwd), .touch_rd_data_i(trd), .adc_rd_data_i(ard),
    .bl_hi_n_i(hi_n), .bl_pwr_i(pwr), .bl_level_o(lvl), .bl_on_o(on),
    .bl_change_o(chg), .qres_o(qres)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // display command: one clock, then sample registered outputs
  task automatic disp_cmd(logic [7:0] c, logic disp_sel);
    @(negedge clk);
    cs_n = disp_sel ? 3'b110 : 3'b111;
    wr_valid = 1'b1;
    wr_data = {8'h00, c};
    @(negedge clk);
    wr_valid = 1'b0;
    cs_n = 3'b111;
  endtask

  task automatic t_reset;
    chk("R1 level", lvl, 6'h20);
    chk("R1 qres", qres, 0);
    chk("R1 on", on, 0);
    chk("R1 change", chg, 0);
  endtask

  task automatic t_route;
    @(negedge clk);
    cs_n = 3'b101; wr_valid = 1'b1; wr_data = 16'h1234; #1;
    chk("R2 touch strobe", {twr, awr}, 2'b10);
    chk("R2 data", pwd, 16'h1234);
    cs_n = 3'b001; #1;
    chk("R2 both strobes", {twr, awr}, 2'b11);
    wr_valid = 1'b0; #1;
    chk("R2 idle", {twr, awr}, 2'b00);
    cs_n = 3'b000; #1; chk("R3 disp wins", rd_data, 0);
    cs_n = 3'b001; #1; chk("R3 touch over adc", rd_data, 16'hA5A5);
    cs_n = 3'b011; #1; chk("R3 adc", rd_data, 16'h5A5A);
    cs_n = 3'b111; #1; chk("R3 none", rd_data, 0);
  endtask

  task automatic t_cmds;
    disp_cmd({3'd0, 5'd1}, 1'b1);  chk("R4 qres set", qres, 1);
    disp_cmd({3'd0, 5'd0}, 1'b1);  chk("R4 qres clr", qres, 0);
    disp_cmd({3'd2, 5'h15}, 1'b1); chk("R5 duty", lvl, 6'h35);
    chk("R8 no pulse pwr off", chg, 0);
    disp_cmd({3'd5, 5'h1f}, 1'b1); chk("R7 level", lvl, 6'h35);
    chk("R7 qres", qres, 0);
    disp_cmd({3'd1, 5'h1f}, 1'b1); chk("R7 addr1", {qres, lvl}, {1'b0, 6'h35});
    disp_cmd({3'd2, 5'h03}, 1'b0); chk("R11 no decode", lvl, 6'h35);
  endtask

  task automatic t_power;
    @(negedge clk); pwr = 1'b1;
    @(negedge clk); chg_chk("R9 rise pulse", 1); chk("R10 on", on, 1);
    @(negedge clk); chk("R9 single pulse", chg, 0);
    disp_cmd({3'd2, 5'h15}, 1'b1); chk("R8 same-value duty pulse", chg, 1);
    @(negedge clk); hi_n = 1'b1;
    @(negedge clk); chk("R6 bit5 cleared", lvl, 6'h15); chk("R8 bit5 pulse", chg, 1);
    @(negedge clk); chk("R8 pulse ends", chg, 0);
    disp_cmd({3'd2, 5'h00}, 1'b1); chk("R10 zero level", {lvl, on}, {6'h00, 1'b0});
    disp_cmd({3'd3, 5'h00}, 1'b1); chk("R7 no pulse", chg, 0);
    @(negedge clk); pwr = 1'b0;
    @(negedge clk); chk("R9 fall pulse", chg, 1);
    @(negedge clk); hi_n = 1'b0;
    @(negedge clk); chk("R6 bit5 set", lvl, 6'h20); chk("R8 gated off", chg, 0);
    chk("R10 off when unpowered", on, 0);
  endtask

  task automatic chg_chk(string req, logic exp);
    chk(req, chg, exp);
  endtask

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route();
    t_cmds();
    t_power();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule